// File: doc/BRIEF.md
# Audio Serial Transmit Channel with Sample FIFO

This block is a single transmit lane of a stereo audio serial port. Software, or a bus adapter in front of it, writes a left sample into a holding register and then a right sample. The right write pushes the stereo pair into a 16-entry FIFO. A bit-clock enable pulse, supplied by an external clock generator, advances the serialiser by one bit position. On each pulse the block drives a word-select line and a serial data line. The sample sits inside each half-frame according to a selectable alignment and a programmed sample width.

Two status flags report the FIFO. The low-fill flag is set while the FIFO level is at or below a programmed threshold. The overrun flag is set when a pair is written while the FIFO is full; that write is dropped. Each flag has a mask bit that gates it into a single interrupt line. Reading the overrun register clears the overrun flag. A flush pulse empties the FIFO.

Top module: `audtx_channel`

## Requirements
- R1: After reset, ws and sd are 0, the FIFO is empty, status[4] is 1 (level 0 is under any threshold), status[5] is 0, and status[3:0] are always 0.
- R2: A left write only loads the left holding register. A right write pushes the pair {held left, written right} into the FIFO, and a held left value is reused by every later right write until it is replaced. Entries leave in write order.
- R3: Each bit_tick advances one bit position. ws is 0 for the left half and 1 for the right half. A half lasts 16, 24 or 32 positions for slot code 0, 1 or 2 (code 3 gives 32). ws and sd change only on an edge where bit_tick is 1.
- R4: With alignment code 3'b001 (standard), the sample MSB is sent at position 1 of the half, one bit after the ws change. Sample bits that would fall past the half are not sent.
- R5: With alignment code 3'b100 (left-justified), the sample MSB is sent at position 0 of the half.
- R6: With alignment code 3'b010 (right-justified), the sample LSB is sent at the last position of the half. Any other alignment code behaves as standard.
- R7: Width code 1..5 selects 12, 16, 20, 24 or 32 bits, and code 0 (or 6, 7) selects the half length. A width above the half length is clipped to it. The low W bits of the written word are sent MSB first, and every position outside the sample is 0.
- R8: A FIFO entry is taken at the first position of the left half. If the FIFO is empty at that point, both halves of the frame are all zeros.
- R9: status[4] is 1 exactly when the FIFO level is at most trig+1, where trig is the 4-bit threshold input.
- R10: A right write that arrives while the FIFO is full is dropped. Fullness is judged before any pop on the same edge. status[5] is 1 from the next edge on.
- R11: An ovr_read pulse clears status[5] on the next edge, unless a new overrun occurs on that same edge.
- R12: A flush pulse makes the FIFO level 0 on the next edge, and the flushed entries are never sent. A right write on the same edge as the flush is dropped without an overrun.
- R13: irq = (status[4] & !mask_empty) | (status[5] & !mask_ovr), with no register between the masks and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per serial bit period |
| fmt_align | input | 3 | Alignment select, one-hot: 001 standard, 010 right, 100 left |
| fmt_wlen | input | 3 | Sample width code |
| fmt_slot | input | 2 | Half-frame length code |
| empty_trig | input | 4 | Low-fill threshold, level limit is value+1 |
| mask_empty | input | 1 | Masks the low-fill flag from irq |
| mask_ovr | input | 1 | Masks the overrun flag from irq |
| wr_left | input | 1 | Left holding register write strobe |
| wr_right | input | 1 | Right write strobe, pushes the pair |
| wr_data | input | 32 | Sample write data |
| fifo_flush | input | 1 | Empties the FIFO |
| ovr_read | input | 1 | Overrun register read, clears the flag |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |
| status | output | 6 | Bit 4 low-fill flag, bit 5 overrun flag |
| irq | output | 1 | Masked interrupt |

## Verification
ws and sd for a bit position are registered on the edge carrying that bit_tick. The bench compares them 1 ns after that edge against a scoreboard model that pops its queue at the first left position. Writes, flushes and overrun reads show in status one edge later, so the bench samples status at the following falling edge. irq follows the masks with no register, so it is sampled a short delay after the masks change. The bench records each pushed pair in the scoreboard half a clock after the write edge. A pop on that same edge therefore sees the FIFO contents as they stood before the write, which is how the hardware behaves.

// File: rtl/audtx_pkg.sv
`timescale 1ns/1ps
package audtx_pkg;

   typedef enum logic [2:0] {
      ALIGN_STD = 3'b001,
      ALIGN_RJ  = 3'b010,
      ALIGN_LJ  = 3'b100
   } align_e;

   typedef struct packed {
      logic [2:0] align;
      logic [2:0] wlen;
      logic [1:0] slot;
   } fmt_cfg_t;

   // half-frame length in bit positions
   function automatic logic [5:0] slot_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 6'd16;
         2'd1:    return 6'd24;
         default: return 6'd32;
      endcase
   endfunction

   // sample width, clipped to the half length and to the datapath width
   function automatic logic [5:0] word_bits(input logic [2:0] code,
                                            input logic [5:0] slot,
                                            input logic [5:0] cap);
      logic [5:0] w;
      case (code)
         3'd1:    w = 6'd12;
         3'd2:    w = 6'd16;
         3'd3:    w = 6'd20;
         3'd4:    w = 6'd24;
         3'd5:    w = 6'd32;
         default: w = slot;
      endcase
      if (w > slot) w = slot;
      if (w > cap)  w = cap;
      return w;
   endfunction

endpackage

// File: rtl/audtx_fifo.sv
`timescale 1ns/1ps
module audtx_fifo #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  level,
   output logic              full,
   output logic              empty
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("audtx_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0] level_q;
   logic [DEPTH-1:0][DATA_W-1:0] ent_flat;
   logic accept, take;

   assign full   = (level_q == CNT_W'(DEPTH));
   assign empty  = (level_q == '0);
   assign level  = level_q;
   assign accept = push && !full && !flush;
   assign take   = pop && !empty;
   assign rdata  = ent_flat[rd_ptr_q];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [DATA_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q <= '0;
         else if (accept && wr_ptr_q == PTR_W'(g))
            ent_q <= wdata;
      end
      assign ent_flat[g] = ent_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         level_q  <= '0;
      end else if (flush) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         level_q  <= '0;
      end else begin
         if (accept) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
         if (take)   rd_ptr_q <= rd_ptr_q + PTR_W'(1);
         level_q <= level_q + CNT_W'(accept) - CNT_W'(take);
      end
   end

   // R10
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (level == CNT_W'(DEPTH)));

   // R12
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0));

   // R2
   push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !flush && !pop) |=> (level == $past(level) + CNT_W'(1)));

endmodule

// File: rtl/audtx_serdes.sv
`timescale 1ns/1ps
module audtx_serdes #(
   parameter int unsigned SMP_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_tick,
   input  audtx_pkg::fmt_cfg_t  fmt,
   input  logic                 head_valid,
   input  logic [SMP_W-1:0]     head_l,
   input  logic [SMP_W-1:0]     head_r,
   output logic                 pop,
   output logic                 ws,
   output logic                 sd
);
   import audtx_pkg::*;

   generate
      if (SMP_W < 12 || SMP_W > 32) begin : g_bad_width
         $error("audtx_serdes: SMP_W must lie in 12..32");
      end
   endgenerate

   localparam int unsigned POS_W = 6;

   logic [POS_W-1:0] pos_q, slot_len, wrd_len, first;
   logic             half_q, ws_q, sd_q;
   logic [SMP_W-1:0] frm_l_q, frm_r_q, cur_smp;
   logic             frame_start, last_pos, in_smp, bit_val;
   logic [6:0]       rel, idx;

   assign slot_len    = slot_bits(fmt.slot);
   assign wrd_len     = word_bits(fmt.wlen, slot_len, POS_W'(SMP_W));
   assign frame_start = !half_q && (pos_q == '0);
   assign last_pos    = (pos_q >= slot_len - POS_W'(1));
   assign pop         = bit_tick && frame_start && head_valid;

   always_comb begin
      if (half_q)
         cur_smp = frm_r_q;
      else if (frame_start)
         cur_smp = head_valid ? head_l : '0;
      else
         cur_smp = frm_l_q;
   end

   // position of the sample MSB inside the half
   always_comb begin
      case (fmt.align)
         ALIGN_LJ: first = '0;
         ALIGN_RJ: first = slot_len - wrd_len;
         default:  first = POS_W'(1);
      endcase
   end

   assign rel    = {1'b0, pos_q} - {1'b0, first};
   assign in_smp = (pos_q >= first) && (rel < {1'b0, wrd_len});
   assign idx    = {1'b0, wrd_len} - 7'd1 - rel;

   always_comb begin
      bit_val = 1'b0;
      for (int i = 0; i < SMP_W; i++) begin
         if (in_smp && idx == 7'(i)) bit_val = cur_smp[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         half_q  <= 1'b0;
         ws_q    <= 1'b0;
         sd_q    <= 1'b0;
         frm_l_q <= '0;
         frm_r_q <= '0;
      end else if (bit_tick) begin
         ws_q <= half_q;
         sd_q <= bit_val;
         if (frame_start) begin
            frm_l_q <= cur_smp;
            frm_r_q <= head_valid ? head_r : '0;
         end
         if (last_pos) begin
            pos_q  <= '0;
            half_q <= !half_q;
         end else begin
            pos_q <= pos_q + POS_W'(1);
         end
      end
   end

   assign ws = ws_q;
   assign sd = sd_q;

   // R3
   line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> ($stable(ws) && $stable(sd)));

   // R3
   half_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && last_pos) |=> (half_q != $past(half_q)));

   // R8
   pop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (pos_q == POS_W'(1) || slot_len == POS_W'(1)));

endmodule

// File: rtl/audtx_stat.sv
`timescale 1ns/1ps
module audtx_stat #(
   parameter int unsigned CNT_W  = 5,
   parameter int unsigned TRIG_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  level,
   input  logic [TRIG_W-1:0] trig,
   input  logic              ovr_evt,
   input  logic              ovr_clr,
   input  logic              mask_empty,
   input  logic              mask_ovr,
   output logic [5:0]        status,
   output logic              irq
);

   generate
      if (TRIG_W + 1 < CNT_W) begin : g_bad_trig
         $error("audtx_stat: threshold narrower than the level range");
      end
   endgenerate

   localparam int unsigned CMP_W = ((CNT_W > TRIG_W) ? CNT_W : TRIG_W) + 1;

   logic [CMP_W-1:0] thr;
   logic             low_fill, ovr_q;

   assign thr      = CMP_W'(trig) + CMP_W'(1);
   assign low_fill = (CMP_W'(level) <= thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovr_q <= 1'b0;
      else if (ovr_evt)
         ovr_q <= 1'b1;
      else if (ovr_clr)
         ovr_q <= 1'b0;
   end

   assign status = {ovr_q, low_fill, 4'b0000};
   assign irq    = (low_fill && !mask_empty) || (ovr_q && !mask_ovr);

   // R10
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> status[5]);

   // R11
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_clr && !ovr_evt) |=> !status[5]);

endmodule

// File: rtl/audtx_channel.sv
`timescale 1ns/1ps
module audtx_channel #(
   parameter int unsigned SMP_W = 32,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned TRIG_W = $clog2(DEPTH),
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic [2:0]        fmt_align,
   input  logic [2:0]        fmt_wlen,
   input  logic [1:0]        fmt_slot,
   input  logic [TRIG_W-1:0] empty_trig,
   input  logic              mask_empty,
   input  logic              mask_ovr,
   input  logic              wr_left,
   input  logic              wr_right,
   input  logic [SMP_W-1:0]  wr_data,
   input  logic              fifo_flush,
   input  logic              ovr_read,
   output logic              ws,
   output logic              sd,
   output logic [5:0]        status,
   output logic              irq
);
   import audtx_pkg::*;

   logic [SMP_W-1:0]   left_hold_q;
   logic [2*SMP_W-1:0] head;
   logic [CNT_W-1:0]   level;
   logic               full, empty, pop, ovr_evt;
   fmt_cfg_t           fmt;

   assign fmt     = '{align: fmt_align, wlen: fmt_wlen, slot: fmt_slot};
   assign ovr_evt = wr_right && full && !fifo_flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left_hold_q <= '0;
      else if (wr_left)
         left_hold_q <= wr_data;
   end

   audtx_fifo #(.DATA_W(2 * SMP_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (fifo_flush),
      .push  (wr_right),
      .wdata ({left_hold_q, wr_data}),
      .pop   (pop),
      .rdata (head),
      .level (level),
      .full  (full),
      .empty (empty)
   );

   audtx_serdes #(.SMP_W(SMP_W)) u_serdes (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_tick   (bit_tick),
      .fmt        (fmt),
      .head_valid (!empty),
      .head_l     (head[2*SMP_W-1:SMP_W]),
      .head_r     (head[SMP_W-1:0]),
      .pop        (pop),
      .ws         (ws),
      .sd         (sd)
   );

   audtx_stat #(.CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .level      (level),
      .trig       (empty_trig),
      .ovr_evt    (ovr_evt),
      .ovr_clr    (ovr_read),
      .mask_empty (mask_empty),
      .mask_ovr   (mask_ovr),
      .status     (status),
      .irq        (irq)
   );

   // R13
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_empty && mask_ovr) |-> !irq);

   // R2
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_left |=> $stable(left_hold_q));

endmodule

// File: tb/test_audtx_channel.sv
`timescale 1ns/1ps
module test_audtx_channel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_tick = 1'b0;
   logic [2:0]  fmt_align = 3'b001;
   logic [2:0]  fmt_wlen = 3'd2;
   logic [1:0]  fmt_slot = 2'd2;
   logic [3:0]  empty_trig = 4'd0;
   logic        mask_empty = 1'b1, mask_ovr = 1'b1;
   logic        wr_left = 1'b0, wr_right = 1'b0;
   logic [31:0] wr_data = '0;
   logic        fifo_flush = 1'b0, ovr_read = 1'b0;
   logic        ws, sd, irq;
   logic [5:0]  status;

   always #2 clk = ~clk;

   audtx_channel i_audtx_channel (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
      .fmt_align(fmt_align), .fmt_wlen(fmt_wlen), .fmt_slot(fmt_slot),
      .empty_trig(empty_trig), .mask_empty(mask_empty), .mask_ovr(mask_ovr),
      .wr_left(wr_left), .wr_right(wr_right), .wr_data(wr_data),
      .fifo_flush(fifo_flush), .ovr_read(ovr_read),
      .ws(ws), .sd(sd), .status(status), .irq(irq)
   );

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [63:0] q[$];
   logic [31:0] hold_l = '0;
   int m_pos = 0;
   bit m_half = 0;
   logic [31:0] m_l = '0, m_r = '0;
   bit tick_en = 0, stop_req = 0;
   int div = 0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int slot_len();
      case (fmt_slot)
         2'd0: return 16;
         2'd1: return 24;
         default: return 32;
      endcase
   endfunction

   // expected bit at position p, built from R4..R7
   function automatic logic exp_bit(input logic [31:0] s, input int p);
      int S = slot_len();
      int W;
      int first;
      case (fmt_wlen)
         3'd1: W = 12;
         3'd2: W = 16;
         3'd3: W = 20;
         3'd4: W = 24;
         3'd5: W = 32;
         default: W = S;
      endcase
      if (W > S) W = S;
      if (fmt_align == 3'b100) first = 0;
      else if (fmt_align == 3'b010) first = S - W;
      else first = 1;
      if (p < first || p - first >= W) return 1'b0;
      return s[W - 1 - (p - first)];
   endfunction

   // bit-clock enable generator, stops only at a frame boundary
   always @(negedge clk) begin
      if (stop_req && m_pos == 0 && !m_half) tick_en = 0;
      bit_tick = tick_en && (div == 3);
      div = (div + 1) % 4;
   end

   // monitor / scoreboard
   always @(posedge clk) begin
      logic t;
      t = bit_tick;
      if (rst_n && t) begin
         string at;
         #1;
         if (m_pos == 0 && !m_half) begin
            if (q.size() > 0) begin
               logic [63:0] pr;
               pr = q.pop_front();
               m_l = pr[63:32];
               m_r = pr[31:0];
            end else begin
               m_l = '0;
               m_r = '0;
            end
         end
         at = (fmt_align == 3'b100) ? "R5" : (fmt_align == 3'b010) ? "R6" : "R4";
         check("R3 ws level", ws, m_half);
         check($sformatf("%s R2 R7 R8 sd pos %0d half %0d", at, m_pos, m_half),
               sd, exp_bit(m_half ? m_r : m_l, m_pos));
         if (m_pos == slot_len() - 1) begin
            m_pos = 0;
            m_half = !m_half;
         end else begin
            m_pos++;
         end
      end
   end

   task automatic write_left(input logic [31:0] l);
      @(negedge clk);
      wr_left = 1; wr_data = l;
      @(negedge clk);
      wr_left = 0;
      hold_l = l;
   endtask

   task automatic write_right(input logic [31:0] r, input bit with_flush);
      bit was_full;
      @(negedge clk);
      was_full = (q.size() >= 16);
      wr_right = 1; wr_data = r; fifo_flush = with_flush;
      @(negedge clk);
      wr_right = 0; fifo_flush = 0;
      if (with_flush) q.delete();
      else if (!was_full) q.push_back({hold_l, r});
   endtask

   task automatic write_pair(input logic [31:0] l, input logic [31:0] r);
      write_left(l);
      write_right(r, 0);
   endtask

   task automatic run_frames(input int n);
      tick_en = 1;
      repeat (n * 2 * slot_len() * 4) @(negedge clk);
      stop_req = 1;
      wait (!tick_en);
      stop_req = 0;
      @(negedge clk);
   endtask

   task automatic finish_test();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_test();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      check("R1 ws", ws, 0);
      check("R1 sd", sd, 0);
      check("R1 status", status, 6'h10);
      check("R13 irq all masked", irq, 0);
      rst_n = 1;
      @(negedge clk);
      mask_empty = 0;
      #1 check("R13 irq low-fill unmasked", irq, 1);
      mask_empty = 1;
      #1 check("R13 irq masked again", irq, 0);

      // standard, 16 bit, 32 slot
      fmt_align = 3'b001; fmt_wlen = 3'd2; fmt_slot = 2'd2; empty_trig = 4'd0;
      write_pair(32'h0000_A5C3, 32'h1234_8001);
      write_pair(32'hFFFF_7FFF, 32'h0000_0001);
      write_pair(32'h0000_8000, 32'h0000_FFFF);
      check("R9 level 3 over threshold 1", status[4], 0);
      run_frames(5);
      check("R9 drained", status[4], 1);

      // left-justified 24 bit
      fmt_align = 3'b100; fmt_wlen = 3'd4;
      write_pair(32'h00AB_CDEF, 32'h0080_0001);
      write_pair(32'h0012_3456, 32'h00FF_FFFE);
      run_frames(3);

      // right-justified 20 bit in 24 slot
      fmt_align = 3'b010; fmt_wlen = 3'd3; fmt_slot = 2'd1;
      write_pair(32'h000F_0F0F, 32'h0008_0001);
      write_pair(32'h0007_FFFF, 32'h0001_2345);
      run_frames(3);

      // width code 0 in 16 slot, left-justified
      fmt_align = 3'b100; fmt_wlen = 3'd0; fmt_slot = 2'd0;
      write_pair(32'h0000_C001, 32'h0000_5AA5);
      run_frames(2);

      // 32-bit width clipped to 24 slot, standard
      fmt_align = 3'b001; fmt_wlen = 3'd5; fmt_slot = 2'd1;
      write_pair(32'hDEAD_BEEF, 32'h8000_0001);
      run_frames(2);

      // right-justified 32 bit, slot code 3
      fmt_align = 3'b010; fmt_wlen = 3'd5; fmt_slot = 2'd3;
      write_pair(32'h8000_0001, 32'h7654_3210);
      run_frames(2);

      // R2 held left reused by two right writes
      fmt_align = 3'b100; fmt_wlen = 3'd2; fmt_slot = 2'd2;
      write_left(32'h0000_BEEF);
      write_right(32'h0000_1111, 0);
      write_right(32'h0000_2222, 0);
      run_frames(3);

      // R9 threshold 3 gives level limit 4
      empty_trig = 4'd3;
      for (int i = 0; i < 4; i++) write_pair(32'h100 + i, 32'h200 + i);
      check("R9 level 4 at limit", status[4], 1);
      write_pair(32'h0000_0444, 32'h0000_0555);
      check("R9 level 5 over limit", status[4], 0);

      // R10 fill then overrun
      empty_trig = 4'd0;
      for (int i = 5; i < 16; i++) write_pair(32'h1000 + i, 32'h2000 + i);
      check("R10 no overrun at full", status[5], 0);
      write_pair(32'h0000_DEAD, 32'h0000_DEAD);
      check("R10 overrun flag", status[5], 1);
      mask_ovr = 0;
      #1 check("R13 irq overrun unmasked", irq, 1);
      mask_ovr = 1;
      #1 check("R13 irq overrun masked", irq, 0);
      @(negedge clk); ovr_read = 1;
      @(negedge clk); ovr_read = 0;
      check("R11 overrun cleared by read", status[5], 0);
      run_frames(17);
      check("R10 FIFO drained", status[4], 1);

      // R12 flush
      write_pair(32'h0000_1357, 32'h0000_2468);
      write_pair(32'h0000_9ABC, 32'h0000_DEF0);
      write_pair(32'h0000_0F0F, 32'h0000_F0F0);
      check("R12 level 3 before flush", status[4], 0);
      @(negedge clk); fifo_flush = 1;
      @(negedge clk); fifo_flush = 0;
      q.delete();
      check("R12 empty after flush", status[4], 1);
      write_left(32'h0000_7777);
      write_right(32'h0000_8888, 1);
      check("R12 write with flush no overrun", status[5], 0);
      check("R12 write with flush dropped", status[4], 1);
      run_frames(2);

      finish_test();
   end

endmodule